// File: doc/BRIEF.md
# Operation-Matched Completion Delay Handshake

This block stands beside a multi-function arithmetic unit that has no completion output of its own. When a controller raises a request and presents an operation code, the block starts a countdown. The length of the countdown is chosen for that operation and models the operation's worst-case settling path. When the countdown ends the block raises acknowledge. The controller then lowers its request, and the block lowers acknowledge. This is a four-phase, return-to-zero exchange.

Time is counted in ticks of a fast free-running reference clock. One tick stands for one unit delay element. Each operation's settling path, given in picoseconds, is stretched by a margin ratio that allows for temperature and supply drift. The result is rounded up to whole units, so acknowledge is never early.

The table of settling paths, the unit delay and the margin ratio are all parameters. The countdown register width follows from the largest delay in the table.

Top module: `mdly_ack_wrapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ack_o` is low after that edge and no countdown is running.
- R2: The delay for operation code k is D(k) = ceil(1.5 × P(k) / 100), where P(k) is the k-th 16-bit field of `CRIT_PS_TABLE` (bits 16k+15:16k). The default settling paths for codes 0 through 7 are 1200, 1300, 400, 400, 450, 600, 4100 and 7300 ps, which give 18, 20, 6, 6, 7, 9, 62 and 110 ticks.
- R3: A request is accepted at the edge where `req_i` is sampled high in the idle state. `ack_o` rises exactly D ticks after that edge and is never high earlier.
- R4: Once `ack_o` is high, it stays high for as long as `req_i` is sampled high.
- R5: At the first edge where `req_i` is sampled low while `ack_o` is high, `ack_o` goes low.
- R6: A new countdown starts only when `req_i` is high and `ack_o` is low. A request kept high through the acknowledge phase does not restart the countdown or produce a second acknowledge. A request raised after `ack_o` falls gets a fresh, full delay.
- R7: The 3-bit operation code on `op_i` is taken only at the accepting edge. Changes to it during the countdown or the acknowledge phase do not change the timing of that exchange.
- R8: If `req_i` falls during the countdown, the countdown is not aborted. `ack_o` still rises D ticks after acceptance and then goes low one tick later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock; one period is one unit delay |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request from the controller, four-phase |
| op_i | input | OP_W (3) | Operation code that selects the delay |
| ack_o | output | 1 | Completion acknowledge to the controller |

## Verification
A wrong countdown load or decrement shows up in the cycle where `ack_o` first rises. The rise comes early or late by the size of the error, within at most 110 ticks of the request. So every exchange is timed tick by tick against the delay computed from the settling-path table.

A sequencer stuck in the acknowledge state, or one that restarts from it, shows one tick after `req_i` falls: `ack_o` stays high, or a second rise appears during a held request. The bench watches `ack_o` on every tick of the hold and release phases, including after random operation-code changes and early request drops.

// File: rtl/mdly_pkg.sv
// Package mdly_pkg
// Shared types and constant functions for the matched-delay acknowledge
// wrapper. Assumes all arithmetic fits in 32-bit unsigned integers.
package mdly_pkg;

    // Sequencer states of the four-phase exchange
    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_COUNT   = 2'd1,
        HS_ACKHIGH = 2'd2
    } hs_state_e;

    // Ticks for one path: ceil(path * num / (unit * den)), never below one
    function automatic int unsigned path_ticks(
        input int unsigned path_ps,
        input int unsigned unit_ps,
        input int unsigned num,
        input int unsigned den
    );
        int unsigned q;
        q = (path_ps * num + unit_ps * den - 1) / (unit_ps * den);
        return (q == 0) ? 1 : q;
    endfunction

endpackage

// File: rtl/mdly_delay_table.sv
// Module mdly_delay_table
// Turns the per-operation settling-path table (picoseconds, packed fields)
// into tick counts with margin applied, and looks one up by operation code.
// Assumes NUM_OPS <= 2**OP_W; codes beyond NUM_OPS reuse the last entry.
module mdly_delay_table #(
    parameter int unsigned NUM_OPS    = 8,
    parameter int unsigned OP_W       = 3,
    parameter int unsigned PS_W       = 16,
    parameter int unsigned UNIT_PS    = 100,
    parameter int unsigned MARGIN_NUM = 3,
    parameter int unsigned MARGIN_DEN = 2,
    parameter int unsigned CNT_W      = 7,
    parameter logic [NUM_OPS*PS_W-1:0] CRIT_PS_TABLE = '0
) (
    input  logic [OP_W-1:0]  op_i,
    output logic [CNT_W-1:0] ticks_o
);
    localparam int unsigned OP_SPAN = 1 << OP_W;

    logic [CNT_W-1:0] tbl [OP_SPAN];

    // One constant entry per code; unused codes alias the last real entry
    for (genvar g = 0; g < OP_SPAN; g++) begin : g_entry
        localparam int unsigned SRC = (g < NUM_OPS) ? g : NUM_OPS - 1;
        localparam int unsigned TK  = mdly_pkg::path_ticks(
            int'(CRIT_PS_TABLE[SRC*PS_W +: PS_W]), UNIT_PS, MARGIN_NUM, MARGIN_DEN);
        assign tbl[g] = CNT_W'(TK);
    end

    // Select the entry for the presented code
    always_comb begin
        ticks_o = tbl[op_i];
    end

endmodule

// File: rtl/mdly_down_counter.sv
// Module mdly_down_counter
// Loadable down-counter standing in for a chain of unit delay elements.
// Assumes a loaded value of at least one. expire_o is high during the
// last tick of a run; the counter stops by itself after that tick.
module mdly_down_counter #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             running_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Load, count down and stop at the end of the run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == CNT_W'(1)) begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // Flag the final tick of a run
    always_comb begin
        running_o = run_q;
        expire_o  = run_q && (cnt_q == CNT_W'(1));
    end

endmodule

// File: rtl/mdly_hs_seq.sv
// Module mdly_hs_seq
// Four-phase sequencer: accepts a request only while acknowledge is low,
// waits for the countdown to expire, raises acknowledge, and drops it once
// the request has been seen low. The request level is ignored during the
// countdown.
module mdly_hs_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic expire_i,
    output logic load_o,
    output logic ack_o
);
    import mdly_pkg::*;

    hs_state_e state_q, state_d;
    logic      ack_q,   ack_d;

    // Next state and acknowledge level
    always_comb begin
        state_d = state_q;
        ack_d   = ack_q;
        load_o  = 1'b0;
        unique case (state_q)
            HS_IDLE: begin
                if (req_i && !ack_q) begin
                    load_o  = 1'b1;
                    state_d = HS_COUNT;
                end
            end
            HS_COUNT: begin
                if (expire_i) begin
                    ack_d   = 1'b1;
                    state_d = HS_ACKHIGH;
                end
            end
            HS_ACKHIGH: begin
                if (!req_i) begin
                    ack_d   = 1'b0;
                    state_d = HS_IDLE;
                end
            end
            default: begin
                ack_d   = 1'b0;
                state_d = HS_IDLE;
            end
        endcase
    end

    // State and acknowledge registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_d;
        end
    end

    // Drive the acknowledge output from its register
    always_comb begin
        ack_o = ack_q;
    end

endmodule

// File: rtl/mdly_ack_wrapper.sv
// Module mdly_ack_wrapper
// Top of the matched-delay completion wrapper. It derives the counter width
// from the largest margined delay in the table, then ties together the
// delay lookup, the unit-delay counter and the handshake sequencer.
// Assumes req_i is already synchronous to clk.
module mdly_ack_wrapper #(
    parameter int unsigned NUM_OPS    = 8,
    parameter int unsigned OP_W       = 3,
    parameter int unsigned PS_W       = 16,
    parameter int unsigned UNIT_PS    = 100,
    parameter int unsigned MARGIN_NUM = 3,
    parameter int unsigned MARGIN_DEN = 2,
    parameter logic [NUM_OPS*PS_W-1:0] CRIT_PS_TABLE = {
        16'd7300, 16'd4100, 16'd600, 16'd450,
        16'd400,  16'd400,  16'd1300, 16'd1200}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic [OP_W-1:0] op_i,
    output logic            ack_o
);
    // Largest margined delay over the whole table
    function automatic int unsigned max_ticks();
        int unsigned m;
        int unsigned t;
        m = 1;
        for (int i = 0; i < NUM_OPS; i++) begin
            t = mdly_pkg::path_ticks(int'(CRIT_PS_TABLE[i*PS_W +: PS_W]),
                                     UNIT_PS, MARGIN_NUM, MARGIN_DEN);
            if (t > m) m = t;
        end
        return m;
    endfunction

    localparam int unsigned MAX_TICKS = max_ticks();
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] sel_ticks;
    logic             cnt_load;
    logic             cnt_expire;
    logic             cnt_running;

    mdly_delay_table #(
        .NUM_OPS(NUM_OPS), .OP_W(OP_W), .PS_W(PS_W), .UNIT_PS(UNIT_PS),
        .MARGIN_NUM(MARGIN_NUM), .MARGIN_DEN(MARGIN_DEN), .CNT_W(CNT_W),
        .CRIT_PS_TABLE(CRIT_PS_TABLE)
    ) u_table (
        .op_i   (op_i),
        .ticks_o(sel_ticks)
    );

    mdly_down_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cnt_load),
        .load_val_i(sel_ticks),
        .running_o (cnt_running),
        .expire_o  (cnt_expire)
    );

    mdly_hs_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .expire_i(cnt_expire),
        .load_o  (cnt_load),
        .ack_o   (ack_o)
    );

endmodule

// File: rtl/mdly_ack_wrapper_chk.sv
// Module mdly_ack_wrapper_chk
// Protocol checker bound into mdly_ack_wrapper. It relates the handshake
// ports to the counter's expire and load strobes.
module mdly_ack_wrapper_chk (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic ack_o,
    input logic expire,
    input logic load,
    input logic running
);
    // R1: reset leaves acknowledge low
    assert_reset_clears_ack_R1: assert property (@(posedge clk)
        !rst_n |=> !ack_o);

    // R3: acknowledge rises only at the end of a countdown
    assert_ack_not_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(expire));

    // R4: a held request keeps acknowledge high
    assert_ack_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && req_i) |=> ack_o);

    // R5: a released request clears acknowledge on the next tick
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !req_i) |=> !ack_o);

    // R6: a countdown starts only with request high and acknowledge low
    assert_start_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (req_i && !ack_o && !running));

    // R8: a started countdown runs to its end whatever the request does
    assert_count_not_aborted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !expire) |=> running);

endmodule

bind mdly_ack_wrapper mdly_ack_wrapper_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .ack_o  (ack_o),
    .expire (cnt_expire),
    .load   (cnt_load),
    .running(cnt_running)
);

// File: tb/mdly_ack_wrapper_bench.sv
module mdly_ack_wrapper_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_i;
    logic [2:0] op_i;
    logic       ack_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    mdly_ack_wrapper u_mdly_ack_wrapper (
        .clk  (clk),
        .rst_n(rst_n),
        .req_i(req_i),
        .op_i (op_i),
        .ack_o(ack_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected delay from the requirement formula (R2)
    function automatic int exp_delay(input int op);
        int path_ps [8] = '{1200, 1300, 400, 400, 450, 600, 4100, 7300};
        return (path_ps[op] * 3 + 199) / 200;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One exchange, started at a negedge; all sampling at negedges
    task automatic handshake(input int op, input int hold, input bit op_change,
                             input bit early_drop);
        int d;
        int first_hi;
        d = exp_delay(op);
        first_hi = 0;
        op_i  = 3'(op);
        req_i = 1'b1;
        for (int k = 1; k <= d + 1; k++) begin
            @(negedge clk);
            if (ack_o && first_hi == 0) first_hi = k;
            if (k == 2 && op_change) op_i = 3'(op ^ 5);
            if (k == 2 && early_drop) req_i = 1'b0;
        end
        check(first_hi == d + 1, "R3/R2/R7 ack rise tick", first_hi, d + 1);
        if (early_drop) begin
            @(negedge clk);
            check(ack_o == 1'b0, "R8 ack clears after early drop", ack_o, 0);
            return;
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(ack_o == 1'b1, "R4/R6 ack held with request high", ack_o, 1);
        end
        req_i = 1'b0;
        @(negedge clk);
        check(ack_o == 1'b0, "R5 ack clears one tick after release", ack_o, 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        int gap;
        seed  = $urandom(32'h5eed_0c1a);
        rst_n = 1'b0;
        req_i = 1'b1;
        op_i  = 3'd7;
        repeat (3) @(negedge clk);
        check(ack_o == 1'b0, "R1 ack low in reset with request high", ack_o, 0);
        req_i = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ack_o == 1'b0, "R1 ack low after reset", ack_o, 0);

        // Directed sweep of every code (R2)
        for (int op = 0; op < 8; op++) begin
            handshake(op, 1, 1'b0, 1'b0);
        end
        // Back-to-back request right after ack falls gets a full delay (R6)
        handshake(6, 0, 1'b0, 1'b0);
        handshake(2, 0, 1'b0, 1'b0);
        // Long hold: no restart, no second pulse (R6)
        handshake(4, 150, 1'b0, 1'b0);
        // Code changes mid-count are ignored (R7)
        handshake(7, 2, 1'b1, 1'b0);
        handshake(0, 2, 1'b1, 1'b0);
        // Early request drop does not abort (R8)
        handshake(1, 0, 1'b0, 1'b1);
        handshake(5, 0, 1'b0, 1'b1);

        // Constrained random exchanges
        for (int i = 0; i < 40; i++) begin
            gap = $urandom_range(0, 5);
            for (int g = 0; g < gap; g++) begin
                op_i = 3'($urandom_range(0, 7));
                @(negedge clk);
                check(ack_o == 1'b0, "R6 no ack while idle", ack_o, 0);
            end
            handshake($urandom_range(0, 7), $urandom_range(0, 6),
                      1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
        end

        // Reset during a countdown clears everything (R1)
        op_i  = 3'd7;
        req_i = 1'b1;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        req_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (120) @(negedge clk);
        check(ack_o == 1'b0, "R1 reset cancels countdown", ack_o, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule